// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-page to physical-page translations so that a load, store or instruction fetch can be translated in the same cycle it is presented. Every slot is compared against the incoming virtual page number at once. On a hit, the stored physical page number is joined to the untouched page offset to form the physical address. The access type is also checked against the slot's rights, and a protection fault is raised when the rights do not allow that access.

Each slot keeps a written-since-load flag and a recently-used flag for the replacement and write-back software. A write that hits and is allowed marks its page as written. Any hit marks its page as used. A single-cycle input clears every used flag at once, which supports an approximate least-recently-used sweep. The block never reads page tables itself. On a miss it raises a miss indication, and an external handler installs the translation through a refill port that names the target slot. A second input drops every translation at once.

The hit slot's two status flags are returned with each lookup. This lets the handler see them when it decides what to replace.

Top module: `tlb_fa`

## Requirements
- R1: After reset no slot holds a translation, so every lookup reports a miss.
- R2: On a hit, `lk_hit` rises in the same cycle. `lk_paddr` is the slot's physical page number in the upper bits, followed by the low `log2(PAGE_BYTES)` bits of `lk_vaddr` unchanged.
- R3: A lookup whose virtual page number matches no valid slot raises `lk_miss` with `lk_hit` low. `lk_hit` and `lk_miss` are never high together.
- R4: Access codes on `lk_acc` are 0 = read, 1 = write and 2 = fetch. Rights codes are 0 = read only, 1 = read and write, 2 = read and fetch, and 3 = no access. A hit whose access is not allowed by the slot's rights raises `lk_fault` in the same cycle. Code 3 on `lk_acc` is never allowed.
- R5: A write that hits and is allowed sets the slot's written flag, which `lk_dirty` shows from the next cycle. A faulting write leaves the flag unchanged.
- R6: Any hit, including a faulting one, sets the slot's used flag, which `lk_ref` shows from the next cycle.
- R7: A `clr_ref` pulse clears every used flag from the next cycle. A hit in the same cycle still sets its own flag.
- R8: With `wr_en` high, slot `wr_slot` takes `wr_vpn`, `wr_ppn` and `wr_rights` at the next edge. It becomes valid with both status flags cleared.
- R9: When a refill and a lookup hit the same slot in one cycle, the lookup reports a miss and leaves that slot's flags untouched. The refill takes effect.
- R10: An `inval_all` pulse drops every translation from the next cycle. A refill in the same cycle still installs its slot.
- R11: With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` stay low and no status flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access type of the lookup |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation, handler must refill |
| lk_fault | output | 1 | Hit, but rights forbid the access |
| lk_paddr | output | PA_W | Translated physical address (zero when no hit) |
| lk_dirty | output | 1 | Written flag of the hit slot |
| lk_ref | output | 1 | Used flag of the hit slot |
| wr_en | input | 1 | Refill strobe |
| wr_slot | input | log2(ENTRIES) | Slot to refill |
| wr_vpn | input | VA_W-log2(PAGE_BYTES) | Virtual page number to install |
| wr_ppn | input | PA_W-log2(PAGE_BYTES) | Physical page number to install |
| wr_rights | input | 2 | Rights code to install |
| clr_ref | input | 1 | Clear every used flag |
| inval_all | input | 1 | Drop every translation |

## Verification
Hit, miss, fault and address are combinational. They are due in the same cycle as the lookup, so the bench drives at the falling edge and samples one time unit later, before the rising edge. Flag updates, refills, clears and invalidations land on the next rising edge. The bench sees them through the next lookup, which it presents at the following falling edge. Same-cycle collisions are driven together in one cycle, and their outcome is read both in that cycle and in the cycle after.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // lookup access type
    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // per-slot rights code
    localparam logic [1:0] RIGHTS_RO   = 2'd0;
    localparam logic [1:0] RIGHTS_RW   = 2'd1;
    localparam logic [1:0] RIGHTS_RX   = 2'd2;
    localparam logic [1:0] RIGHTS_NONE = 2'd3;

    typedef struct packed {
        logic       valid;
        logic       dirty;
        logic       refd;
        logic [1:0] rights;
    } slot_flags_t;

    function automatic logic access_allowed(logic [1:0] rights, logic [1:0] acc);
        logic ok;
        ok = 1'b0;
        case (rights)
            RIGHTS_RO: ok = (acc == ACC_READ);
            RIGHTS_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
            RIGHTS_RX: ok = (acc == ACC_READ) || (acc == ACC_FETCH);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 22
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            slot_valid,
    input  logic [ENTRIES-1:0]            slot_blocked,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_valid[g] && !slot_blocked[g] && (tags[g] == key);
    end

endmodule

// File: rtl/tlb_enc.sv
module tlb_enc #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] onehot,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (onehot[i]) begin
                idx = idx | IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter  int ENTRIES    = 16,
    parameter  int VA_W       = 32,
    parameter  int PA_W       = 32,
    parameter  int PAGE_BYTES = 1024,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int VPN_W      = VA_W - OFF_W,
    localparam int PPN_W      = PA_W - OFF_W,
    localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_dirty,
    output logic             lk_ref,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_rights,
    input  logic             clr_ref,
    input  logic             inval_all
);

    typedef struct packed {
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        slot_flags_t [ENTRIES-1:0]     flags;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] blocked_vec;
    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic               hit_any;
    slot_flags_t        sel_flags;
    logic               perm_ok;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign valid_vec[g]   = st_q.flags[g].valid;
        assign blocked_vec[g] = wr_en && (wr_slot == IDX_W'(g));
    end

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cam (
        .tags        (st_q.vpn),
        .slot_valid  (valid_vec),
        .slot_blocked(blocked_vec),
        .key         (lk_vaddr[VA_W-1:OFF_W]),
        .match       (match_vec)
    );

    tlb_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_enc (
        .onehot(match_vec),
        .idx   (hit_idx),
        .any   (hit_any)
    );

    assign sel_flags = st_q.flags[hit_idx];
    assign perm_ok   = access_allowed(sel_flags.rights, lk_acc);

    // lookup results, combinational in the request cycle
    assign lk_hit   = lk_valid && hit_any;
    assign lk_miss  = lk_valid && !hit_any;
    assign lk_fault = lk_hit && !perm_ok;
    assign lk_paddr = lk_hit ? {st_q.ppn[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;
    assign lk_dirty = lk_hit && sel_flags.dirty;
    assign lk_ref   = lk_hit && sel_flags.refd;

    // next-state: clear sweep, hit update, invalidate, then refill (refill last wins)
    always_comb begin
        st_d = st_q;
        if (clr_ref) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.flags[i].refd = 1'b0;
            end
        end
        if (lk_hit) begin
            st_d.flags[hit_idx].refd = 1'b1;
            if ((lk_acc == ACC_WRITE) && perm_ok) begin
                st_d.flags[hit_idx].dirty = 1'b1;
            end
        end
        if (inval_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.flags[i].valid = 1'b0;
            end
        end
        if (wr_en) begin
            st_d.vpn[wr_slot]          = wr_vpn;
            st_d.ppn[wr_slot]          = wr_ppn;
            st_d.flags[wr_slot].valid  = 1'b1;
            st_d.flags[wr_slot].dirty  = 1'b0;
            st_d.flags[wr_slot].refd   = 1'b0;
            st_d.flags[wr_slot].rights = wr_rights;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic [1:0]      lk_acc,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic            lk_fault,
    input logic [PA_W-1:0] lk_paddr,
    input logic            lk_dirty,
    input logic            lk_ref,
    input logic            wr_en,
    input logic            clr_ref,
    input logic            inval_all
);

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault));

    assert_fault_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    assert_dirty_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_hit && (lk_acc == 2'd1) && !lk_fault && !wr_en && !inval_all)
         && lk_hit && (lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])))
        |-> lk_dirty);

    assert_ref_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_hit && !wr_en && !inval_all)
         && lk_hit && (lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])))
        |-> lk_ref);

    assert_ref_swept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_ref && !lk_valid) && lk_hit) |-> !lk_ref);

    assert_all_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inval_all && !wr_en) && lk_valid) |-> !lk_hit);

endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_tlb_fa.sv
module test_tlb_fa;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 10;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic [1:0]       lk_acc = 2'd0;
    logic             lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
    logic [PA_W-1:0]  lk_paddr;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_slot = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PPN_W-1:0] wr_ppn = '0;
    logic [1:0]       wr_rights = 2'd0;
    logic             clr_ref = 1'b0;
    logic             inval_all = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa i_tlb_fa (.*);

    function automatic logic [VA_W-1:0] va(logic [VPN_W-1:0] vpn, logic [OFF_W-1:0] off);
        return {vpn, off};
    endfunction

    function automatic logic allowed(int r, int a);
        case (r)
            0: return a == 0;
            1: return a <= 1;
            2: return (a == 0) || (a == 2);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic refill(int slot, logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, logic [1:0] r);
        wr_en = 1'b1; wr_slot = 4'(slot); wr_vpn = vpn; wr_ppn = ppn; wr_rights = r;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // present a lookup, wait to settle; caller checks, then end_look closes the cycle
    task automatic start_look(logic [VA_W-1:0] a, logic [1:0] acc);
        lk_valid = 1'b1; lk_vaddr = a; lk_acc = acc;
        #1;
    endtask

    task automatic end_look();
        @(negedge clk);
        lk_valid = 1'b0; clr_ref = 1'b0; inval_all = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        start_look(va(22'h00155, 10'h3C7), 2'd0);
        chk("R1", "miss after reset", 64'(lk_miss), 64'd1);
        chk("R1", "hit after reset", 64'(lk_hit), 64'd0);
        end_look();
    endtask

    task automatic t_refill_hit();
        refill(3, 22'h00155, 22'h002AB, 2'd1);
        refill(15, 22'h3FFFFF, 22'h000000, 2'd1);
        start_look(va(22'h00155, 10'h3C7), 2'd0);
        chk("R8", "hit after refill", 64'(lk_hit), 64'd1);
        chk("R2", "paddr", 64'(lk_paddr), 64'({22'h002AB, 10'h3C7}));
        chk("R8", "dirty after refill", 64'(lk_dirty), 64'd0);
        chk("R8", "ref after refill", 64'(lk_ref), 64'd0);
        end_look();
        start_look(va(22'h3FFFFF, 10'h3FF), 2'd0);
        chk("R2", "paddr top page", 64'(lk_paddr), 64'({22'h000000, 10'h3FF}));
        end_look();
    endtask

    task automatic t_miss();
        start_look(va(22'h00156, 10'h000), 2'd0);
        chk("R3", "miss unknown page", 64'(lk_miss), 64'd1);
        chk("R3", "no hit unknown page", 64'(lk_hit), 64'd0);
        end_look();
    endtask

    task automatic t_perm();
        for (int r = 0; r < 4; r++) refill(4 + r, 22'(32'h100 + r), 22'(32'h40 + r), 2'(r));
        for (int r = 0; r < 4; r++) begin
            for (int a = 0; a < 4; a++) begin
                start_look(va(22'(32'h100 + r), 10'h010), 2'(a));
                chk("R4", $sformatf("hit rights=%0d acc=%0d", r, a), 64'(lk_hit), 64'd1);
                chk("R4", $sformatf("fault rights=%0d acc=%0d", r, a), 64'(lk_fault),
                    64'(!(a < 3 && allowed(r, a))));
                end_look();
            end
        end
    endtask

    task automatic t_flags();
        refill(8, 22'h00200, 22'h00011, 2'd1);
        refill(9, 22'h00201, 22'h00012, 2'd0);
        start_look(va(22'h00200, 10'h004), 2'd1);
        chk("R5", "write allowed", 64'(lk_fault), 64'd0);
        chk("R5", "dirty before write lands", 64'(lk_dirty), 64'd0);
        end_look();
        start_look(va(22'h00200, 10'h008), 2'd0);
        chk("R5", "dirty after write", 64'(lk_dirty), 64'd1);
        chk("R6", "ref after hit", 64'(lk_ref), 64'd1);
        end_look();
        start_look(va(22'h00201, 10'h004), 2'd1);
        chk("R4", "write to read-only faults", 64'(lk_fault), 64'd1);
        end_look();
        start_look(va(22'h00201, 10'h004), 2'd0);
        chk("R5", "faulting write leaves dirty", 64'(lk_dirty), 64'd0);
        chk("R6", "faulting hit sets ref", 64'(lk_ref), 64'd1);
        end_look();
    endtask

    task automatic t_clr_ref();
        clr_ref = 1'b1;
        @(negedge clk);
        clr_ref = 1'b0;
        start_look(va(22'h00200, 10'h000), 2'd0);
        chk("R7", "ref swept", 64'(lk_ref), 64'd0);
        chk("R7", "dirty kept by sweep", 64'(lk_dirty), 64'd1);
        end_look();
        clr_ref = 1'b1;
        start_look(va(22'h00201, 10'h000), 2'd0);
        end_look();
        start_look(va(22'h00201, 10'h000), 2'd0);
        chk("R7", "same-cycle hit keeps ref", 64'(lk_ref), 64'd1);
        end_look();
        start_look(va(22'h00155, 10'h000), 2'd0);
        chk("R7", "other slot swept", 64'(lk_ref), 64'd0);
        end_look();
    endtask

    task automatic t_conflict();
        wr_en = 1'b1; wr_slot = 4'd8; wr_vpn = 22'h00200; wr_ppn = 22'h000AA; wr_rights = 2'd0;
        start_look(va(22'h00200, 10'h123), 2'd1);
        chk("R9", "collision misses", 64'(lk_miss), 64'd1);
        chk("R9", "collision no hit", 64'(lk_hit), 64'd0);
        end_look();
        start_look(va(22'h00200, 10'h123), 2'd0);
        chk("R9", "refill took effect", 64'(lk_paddr), 64'({22'h000AA, 10'h123}));
        chk("R9", "dirty cleared by refill", 64'(lk_dirty), 64'd0);
        chk("R9", "ref not set by collision", 64'(lk_ref), 64'd0);
        end_look();
    endtask

    task automatic t_idle();
        lk_valid = 1'b0; lk_vaddr = va(22'h3FFFFF, 10'h000); lk_acc = 2'd1;
        #1;
        chk("R11", "idle hit", 64'(lk_hit), 64'd0);
        chk("R11", "idle miss", 64'(lk_miss), 64'd0);
        chk("R11", "idle fault", 64'(lk_fault), 64'd0);
        @(negedge clk);
        start_look(va(22'h3FFFFF, 10'h000), 2'd0);
        chk("R11", "idle left dirty", 64'(lk_dirty), 64'd0);
        chk("R11", "idle left ref", 64'(lk_ref), 64'd0);
        end_look();
    endtask

    task automatic t_inval();
        inval_all = 1'b1;
        refill(0, 22'h00003, 22'h00007, 2'd1);
        inval_all = 1'b0;
        start_look(va(22'h00155, 10'h000), 2'd0);
        chk("R10", "dropped slot misses", 64'(lk_miss), 64'd1);
        end_look();
        start_look(va(22'h00003, 10'h055), 2'd0);
        chk("R10", "same-cycle refill kept", 64'(lk_hit), 64'd1);
        chk("R10", "same-cycle refill paddr", 64'(lk_paddr), 64'({22'h00007, 10'h055}));
        end_look();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refill_hit();
        t_miss();
        t_perm();
        t_flags();
        t_clr_ref();
        t_conflict();
        t_idle();
        t_inval();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule